// File: doc/BRIEF.md
# FIFO Almost-Full / Almost-Empty Offset Unit

This block stores the two thresholds that drive a FIFO's early-warning flags: an empty-side offset `n` and a full-side offset `m`. From the word counts it receives, it produces an active-low almost-empty flag in the read clock domain and an active-low almost-full flag in the write clock domain. The FIFO storage and its pointers sit outside the block. The block only receives the counts they produce.

A master reset input is sampled on write-clock edges. While it is low, the level of the `ld` input picks both the default offset pair and how the offsets are programmed afterwards. There are two programming methods. In parallel mode, offsets are written as data-bus-wide slices. In serial mode, they are shifted in one bit per edge. In either mode the offsets can be read back as slices on the read side. A partial reset restarts the slice and bit sequencing and keeps the stored offsets and the chosen method.

Top module: `flag_offset_unit`

## Requirements
- R1: Each write-clock edge that sees `mrst_n` low loads both offsets with a default. The default is 1023 when `ld` is 1 and 127 when `ld` is 0.
- R2: Each write-clock edge that sees `mrst_n` low also fixes the programming method: `ld`=1 selects serial and `ld`=0 selects parallel. The method does not change while `mrst_n` is high. In parallel mode `ser_en` has no effect on the offsets. In serial mode a write with `ld` and `wr_en` both high has no effect on the offsets.
- R3: A parallel write happens on a write-clock edge in parallel mode with `ld` and `wr_en` both high. It stores `din` into the current slice, and the slice index then advances. Slice 0 is empty-offset bits 8:0. Slice 1 is empty-offset bits 13:9, taken from `din[4:0]`. Slices 2 and 3 hold the same two parts of the full offset. After slice 3 the index wraps to slice 0.
- R4: A read happens on a read-clock edge with `ld` and `rd_en` both high. It places the current read slice on `dout`, with unused upper bits zero, and advances a separate read index that follows the same 4-slice order and wrapping. At any other edge `dout` holds its value.
- R5: A serial write happens on a write-clock edge in serial mode with `ser_en` high. It stores `ser_in` into the next of 28 bit positions. The empty offset is filled first, then the full offset, each from its least significant bit upward. After the last position the sequence wraps.
- R6: `almost_full_n` is updated on each write-clock edge. It is 0 when `wr_count` is greater than 16384 minus `m`, and 1 otherwise.
- R7: `almost_empty_n` is updated on each read-clock edge. It is 0 when `rd_count` is less than `n`, and 1 otherwise.
- R8: An edge with `prst_n` low and `mrst_n` high leaves both offsets and the programming method unchanged. It returns the write slice index, the read slice index and the serial bit position to their first entries.
- R9: After `rst_n` is released: `dout` is 0, `almost_full_n` is 1, `almost_empty_n` follows R7 against a default offset of 127, both offsets read back as 127, and the programming method is parallel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_w | input | 1 | Write-side clock |
| clk_r | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| mrst_n | input | 1 | Master reset, active low, sampled on clock edges |
| prst_n | input | 1 | Partial reset, active low, sampled on clock edges |
| ld | input | 1 | Default/method select during master reset; offset access enable afterwards |
| wr_en | input | 1 | Write enable for parallel offset writes |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial offset bit |
| din | input | 9 | Parallel offset slice input |
| wr_count | input | 15 | Word count seen by the write side |
| rd_en | input | 1 | Read enable for offset readback |
| rd_count | input | 15 | Word count seen by the read side |
| dout | output | 9 | Offset readback slice |
| almost_full_n | output | 1 | Almost-full flag, active low |
| almost_empty_n | output | 1 | Almost-empty flag, active low |

## Verification
The bench targets the following corner cases and the failure each would expose:
- Both flag thresholds are probed one count on either side. An off-by-one comparison would assert a flag one word early or late.
- A fifth parallel write and a fifth read are issued to check wrapping. An index that failed to wrap would land the fifth write in the full offset and return a wrong slice.
- Writes on the wrong path are issued in each mode. A design that did not gate them would visibly corrupt the readback.
- A partial reset is applied in the middle of a parallel sequence and in the middle of a serial sequence. A design that cleared the offsets, or kept the stale index, would misplace every later slice or bit.

// File: rtl/foff_pkg.sv
package foff_pkg;

  typedef enum logic {
    PROG_PARALLEL = 1'b0,
    PROG_SERIAL   = 1'b1
  } prog_mode_e;

  localparam int OFS_EMPTY = 0;
  localparam int OFS_FULL  = 1;
  localparam int NUM_OFS   = 2;

  // number of bus slices needed to carry one offset
  function automatic int slices_for(input int off_w, input int data_w);
    return (off_w + data_w - 1) / data_w;
  endfunction

endpackage

// File: rtl/foff_rst_sync.sv
module foff_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/foff_regs.sv
module foff_regs
  import foff_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int OFF_W    = 14,
  parameter int DEF_LOW  = 127,
  parameter int DEF_HIGH = 1023
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mrst_n,
  input  logic                      prst_n,
  input  logic                      ld,
  input  logic                      wr_en,
  input  logic                      ser_en,
  input  logic                      ser_in,
  input  logic [DATA_W-1:0]         din,
  output logic [NUM_OFS*OFF_W-1:0]  ofs_flat,
  output prog_mode_e                mode
);

  localparam int SLICES = slices_for(OFF_W, DATA_W);
  localparam int NWORDS = NUM_OFS * SLICES;
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int NBITS  = NUM_OFS * OFF_W;
  localparam int BC_W   = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [OFF_W-1:0] DEF_L_V = OFF_W'(DEF_LOW);
  localparam logic [OFF_W-1:0] DEF_H_V = OFF_W'(DEF_HIGH);

  logic [NBITS-1:0] ofs_q, ofs_d;
  prog_mode_e       mode_q, mode_d;
  logic [IDX_W-1:0] widx_q, widx_d;
  logic [BC_W-1:0]  bc_q, bc_d;
  logic             run, par_wr, ser_wr;

  assign run    = mrst_n && prst_n;
  assign par_wr = run && ld && wr_en && (mode_q == PROG_PARALLEL);
  assign ser_wr = run && ser_en && (mode_q == PROG_SERIAL);

  // per-bit next state: each flat bit knows its bus slice and serial slot
  for (genvar r = 0; r < NUM_OFS; r++) begin : g_reg
    for (genvar j = 0; j < OFF_W; j++) begin : g_bit
      localparam int WSEL = r * SLICES + j / DATA_W;
      localparam int WPOS = j % DATA_W;
      localparam int SPOS = r * OFF_W + j;
      logic par_hit, ser_hit;
      assign par_hit = par_wr && (widx_q == IDX_W'(WSEL));
      assign ser_hit = ser_wr && (bc_q == BC_W'(SPOS));
      assign ofs_d[SPOS] = !mrst_n ? (ld ? DEF_H_V[j] : DEF_L_V[j]) :
                           par_hit ? din[WPOS] :
                           ser_hit ? ser_in :
                           ofs_q[SPOS];
    end
  end

  always_comb begin
    mode_d = mode_q;
    widx_d = widx_q;
    bc_d   = bc_q;
    if (!mrst_n) begin
      mode_d = ld ? PROG_SERIAL : PROG_PARALLEL;
      widx_d = '0;
      bc_d   = '0;
    end else if (!prst_n) begin
      widx_d = '0;
      bc_d   = '0;
    end else begin
      if (par_wr) begin
        widx_d = (widx_q == IDX_W'(NWORDS - 1)) ? '0 : widx_q + 1'b1;
      end
      if (ser_wr) begin
        bc_d = (bc_q == BC_W'(NBITS - 1)) ? '0 : bc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q  <= {NUM_OFS{DEF_L_V}};
      mode_q <= PROG_PARALLEL;
      widx_q <= '0;
      bc_q   <= '0;
    end else begin
      ofs_q  <= ofs_d;
      mode_q <= mode_d;
      widx_q <= widx_d;
      bc_q   <= bc_d;
    end
  end

  assign ofs_flat = ofs_q;
  assign mode     = mode_q;

endmodule

// File: rtl/foff_readback.sv
module foff_readback
  import foff_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OFF_W  = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mrst_n,
  input  logic                      prst_n,
  input  logic                      ld,
  input  logic                      rd_en,
  input  logic [NUM_OFS*OFF_W-1:0]  ofs_flat,
  output logic [DATA_W-1:0]         dout
);

  localparam int SLICES = slices_for(OFF_W, DATA_W);
  localparam int NWORDS = NUM_OFS * SLICES;
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [NWORDS-1:0][DATA_W-1:0] word;
  logic [IDX_W-1:0]              ridx_q, ridx_d;
  logic [DATA_W-1:0]             dout_q, dout_d;
  logic                          rd_go;

  // slice view of the offsets; bits beyond the offset width read as zero
  for (genvar s = 0; s < NWORDS; s++) begin : g_word
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int RSEL = s / SLICES;
      localparam int JPOS = (s % SLICES) * DATA_W + b;
      if (JPOS < OFF_W) begin : g_on
        assign word[s][b] = ofs_flat[RSEL * OFF_W + JPOS];
      end else begin : g_off
        assign word[s][b] = 1'b0;
      end
    end
  end

  assign rd_go = mrst_n && prst_n && ld && rd_en;

  always_comb begin
    ridx_d = ridx_q;
    dout_d = dout_q;
    if (!mrst_n || !prst_n) begin
      ridx_d = '0;
    end else if (rd_go) begin
      dout_d = word[ridx_q];
      ridx_d = (ridx_q == IDX_W'(NWORDS - 1)) ? '0 : ridx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ridx_q <= '0;
      dout_q <= '0;
    end else begin
      ridx_q <= ridx_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/foff_flag.sv
module foff_flag #(
  parameter int ADDR_W  = 14,
  parameter bit IS_FULL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W:0]   count,
  input  logic [ADDR_W-1:0] offset,
  output logic              flag_n
);

  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(1) << ADDR_W;
  localparam logic RST_V = IS_FULL ? 1'b1 : 1'b0;

  logic hit, flag_d, flag_q;

  if (IS_FULL) begin : g_full
    logic [CNT_W-1:0] limit;
    assign limit = CAP_V - {1'b0, offset};
    assign hit   = count > limit;
  end else begin : g_empty
    assign hit = count < {1'b0, offset};
  end

  assign flag_d = ~hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_V;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_n = flag_q;

endmodule

// File: rtl/flag_offset_unit.sv
module flag_offset_unit
  import foff_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int ADDR_W   = 14,
  parameter int DEF_LOW  = 127,
  parameter int DEF_HIGH = 1023
) (
  input  logic              clk_w,
  input  logic              clk_r,
  input  logic              rst_n,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              ld,
  input  logic              wr_en,
  input  logic              ser_en,
  input  logic              ser_in,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W:0]   wr_count,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   rd_count,
  output logic [DATA_W-1:0] dout,
  output logic              almost_full_n,
  output logic              almost_empty_n
);

  localparam int OFF_W = ADDR_W;

  logic                     rst_w_n, rst_r_n;
  logic [NUM_OFS*OFF_W-1:0] ofs_flat;
  logic [OFF_W-1:0]         off_empty, off_full;
  prog_mode_e               mode;

  foff_rst_sync i_rst_w (.clk(clk_w), .arst_n(rst_n), .rst_n_o(rst_w_n));
  foff_rst_sync i_rst_r (.clk(clk_r), .arst_n(rst_n), .rst_n_o(rst_r_n));

  foff_regs #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .DEF_LOW(DEF_LOW), .DEF_HIGH(DEF_HIGH)
  ) i_regs (
    .clk(clk_w), .rst_n(rst_w_n), .mrst_n(mrst_n), .prst_n(prst_n),
    .ld(ld), .wr_en(wr_en), .ser_en(ser_en), .ser_in(ser_in), .din(din),
    .ofs_flat(ofs_flat), .mode(mode)
  );

  assign off_empty = ofs_flat[OFS_EMPTY*OFF_W +: OFF_W];
  assign off_full  = ofs_flat[OFS_FULL*OFF_W +: OFF_W];

  foff_readback #(.DATA_W(DATA_W), .OFF_W(OFF_W)) i_rdbk (
    .clk(clk_r), .rst_n(rst_r_n), .mrst_n(mrst_n), .prst_n(prst_n),
    .ld(ld), .rd_en(rd_en), .ofs_flat(ofs_flat), .dout(dout)
  );

  foff_flag #(.ADDR_W(ADDR_W), .IS_FULL(1'b1)) i_afull (
    .clk(clk_w), .rst_n(rst_w_n), .count(wr_count), .offset(off_full),
    .flag_n(almost_full_n)
  );

  foff_flag #(.ADDR_W(ADDR_W), .IS_FULL(1'b0)) i_aempty (
    .clk(clk_r), .rst_n(rst_r_n), .count(rd_count), .offset(off_empty),
    .flag_n(almost_empty_n)
  );

endmodule

// File: rtl/flag_offset_unit_chk.sv
module flag_offset_unit_chk
  import foff_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int ADDR_W   = 14,
  parameter int DEF_HIGH = 1023
) (
  input logic              clk_w,
  input logic              clk_r,
  input logic              rst_w_n,
  input logic              rst_r_n,
  input logic              mrst_n,
  input logic              prst_n,
  input logic              ld,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W:0]   wr_count,
  input logic [ADDR_W:0]   rd_count,
  input logic [ADDR_W-1:0] off_empty,
  input logic [ADDR_W-1:0] off_full,
  input prog_mode_e        mode,
  input logic [DATA_W-1:0] dout,
  input logic              almost_full_n,
  input logic              almost_empty_n
);

  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(1) << ADDR_W;
  localparam logic [ADDR_W-1:0] DEF_H_V = ADDR_W'(DEF_HIGH);

  assert_default_high_R1: assert property (@(posedge clk_w) disable iff (!rst_w_n)
    (!mrst_n && ld) |=> (off_empty == DEF_H_V && off_full == DEF_H_V))
    else $error("default offsets not loaded");

  assert_mode_frozen_R2: assert property (@(posedge clk_w) disable iff (!rst_w_n)
    mrst_n |=> $stable(mode))
    else $error("programming method changed outside master reset");

  assert_parallel_blocked_R2: assert property (@(posedge clk_w) disable iff (!rst_w_n)
    (mrst_n && prst_n && mode == PROG_SERIAL && ld && wr_en) |=>
    ($stable(off_empty) && $stable(off_full)))
    else $error("parallel write altered offsets in serial mode");

  assert_dout_hold_R4: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    !(ld && rd_en) |=> $stable(dout))
    else $error("readback output moved without a read");

  assert_afull_low_R6: assert property (@(posedge clk_w) disable iff (!rst_w_n)
    (wr_count > CAP_V - {1'b0, off_full}) |=> !almost_full_n)
    else $error("almost-full not asserted");

  assert_afull_high_R6: assert property (@(posedge clk_w) disable iff (!rst_w_n)
    (wr_count <= CAP_V - {1'b0, off_full}) |=> almost_full_n)
    else $error("almost-full asserted early");

  assert_aempty_R7: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    (rd_count < {1'b0, off_empty}) |=> !almost_empty_n)
    else $error("almost-empty not asserted");

  assert_prst_keeps_R8: assert property (@(posedge clk_w) disable iff (!rst_w_n)
    (mrst_n && !prst_n) |=> ($stable(off_empty) && $stable(off_full) && $stable(mode)))
    else $error("partial reset disturbed offsets");

endmodule

bind flag_offset_unit flag_offset_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEF_HIGH(DEF_HIGH)
) i_chk (
  .clk_w(clk_w), .clk_r(clk_r), .rst_w_n(rst_w_n), .rst_r_n(rst_r_n),
  .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld), .wr_en(wr_en), .rd_en(rd_en),
  .wr_count(wr_count), .rd_count(rd_count), .off_empty(off_empty),
  .off_full(off_full), .mode(mode), .dout(dout),
  .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n)
);

// File: tb/test_flag_offset_unit.sv
module test_flag_offset_unit;

  localparam int CAP = 16384;

  logic        clk = 1'b0;
  logic        rst_n, mrst_n, prst_n, ld, wr_en, ser_en, ser_in, rd_en;
  logic [8:0]  din;
  logic [14:0] wr_count, rd_count;
  logic [8:0]  dout;
  logic        almost_full_n, almost_empty_n;

  always #2 clk = ~clk;

  flag_offset_unit i_flag_offset_unit (
    .clk_w(clk), .clk_r(clk), .rst_n(rst_n), .mrst_n(mrst_n), .prst_n(prst_n),
    .ld(ld), .wr_en(wr_en), .ser_en(ser_en), .ser_in(ser_in), .din(din),
    .wr_count(wr_count), .rd_en(rd_en), .rd_count(rd_count), .dout(dout),
    .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int  m_off [2];
  int  m_serial, m_widx, m_ridx, m_bc, m_dout, m_sh, m_mask, m_r;
  bit  m_af, m_ae, mdl_on;

  initial begin
    m_off[0] = 127; m_off[1] = 127;
    m_serial = 0; m_widx = 0; m_ridx = 0; m_bc = 0; m_dout = 0;
    m_af = 1; m_ae = 0; mdl_on = 0;
  end

  always @(posedge clk) begin
    if (mdl_on) begin
      m_af = !(int'(wr_count) > CAP - m_off[1]);
      m_ae = !(int'(rd_count) < m_off[0]);
      if (mrst_n && prst_n && ld && rd_en) begin
        m_dout = (m_off[m_ridx / 2] >> ((m_ridx % 2) * 9)) & 511;
        m_ridx = (m_ridx + 1) % 4;
      end
      if (!mrst_n || !prst_n) m_ridx = 0;
      if (!mrst_n) begin
        m_serial = ld;
        m_off[0] = ld ? 1023 : 127;
        m_off[1] = m_off[0];
        m_widx = 0; m_bc = 0;
      end else if (!prst_n) begin
        m_widx = 0; m_bc = 0;
      end else begin
        if (m_serial == 0 && ld && wr_en) begin
          m_sh   = (m_widx % 2) * 9;
          m_mask = (m_widx % 2) ? 31 : 511;
          m_r    = m_widx / 2;
          m_off[m_r] = (m_off[m_r] & ~(m_mask << m_sh)) | ((int'(din) & m_mask) << m_sh);
          m_widx = (m_widx + 1) % 4;
        end
        if (m_serial == 1 && ser_en) begin
          m_r = m_bc / 14;
          if (ser_in) m_off[m_r] = m_off[m_r] | (1 << (m_bc % 14));
          else        m_off[m_r] = m_off[m_r] & ~(1 << (m_bc % 14));
          m_bc = (m_bc + 1) % 28;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (mdl_on) begin
      chk(int'(dout) == m_dout, "R4 dout vs model", int'(dout), m_dout);
      chk(almost_full_n == m_af, "R6 almost_full_n vs model", almost_full_n, m_af);
      chk(almost_empty_n == m_ae, "R7 almost_empty_n vs model", almost_empty_n, m_ae);
    end
  end

  task automatic write_word(input int d);
    ld = 1; wr_en = 1; din = 9'(d);
    @(negedge clk);
    ld = 0; wr_en = 0; din = '0;
  endtask

  task automatic write_offs(input int n, input int m);
    write_word(n & 511); write_word(n >> 9);
    write_word(m & 511); write_word(m >> 9);
  endtask

  task automatic read_word(output int w);
    ld = 1; rd_en = 1;
    @(negedge clk);
    w = int'(dout);
    ld = 0; rd_en = 0;
  endtask

  task automatic read_offs(output int n, output int m);
    int w0, w1, w2, w3;
    read_word(w0); read_word(w1); read_word(w2); read_word(w3);
    n = w0 | (w1 << 9);
    m = w2 | (w3 << 9);
  endtask

  task automatic ser_offs(input int n, input int m);
    for (int i = 0; i < 28; i++) begin
      ser_en = 1;
      ser_in = (i < 14) ? n[i] : m[i - 14];
      @(negedge clk);
    end
    ser_en = 0; ser_in = 0;
  endtask

  task automatic master_reset(input logic l);
    mrst_n = 0; ld = l;
    @(negedge clk); @(negedge clk);
    mrst_n = 1; ld = 0;
  endtask

  task automatic partial_reset();
    prst_n = 0;
    @(negedge clk);
    prst_n = 1;
  endtask

  initial begin
    int n, m, w;
    rst_n = 0; mrst_n = 1; prst_n = 1; ld = 0; wr_en = 0; ser_en = 0;
    ser_in = 0; rd_en = 0; din = '0; wr_count = '0; rd_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk(dout == 9'd0, "R9 dout after reset", int'(dout), 0);
    chk(almost_full_n == 1'b1, "R9 almost_full_n after reset", almost_full_n, 1);
    chk(almost_empty_n == 1'b0, "R9 almost_empty_n after reset", almost_empty_n, 0);
    mdl_on = 1;
    read_offs(n, m);
    chk(n == 127, "R9 empty offset default", n, 127);
    chk(m == 127, "R9 full offset default", m, 127);

    // R3 / R4 parallel write and readback
    write_offs(300, 5000);
    read_offs(n, m);
    chk(n == 300, "R3 empty offset parallel", n, 300);
    chk(m == 5000, "R3 full offset parallel", m, 5000);

    // R3 wrap of the write index, R4 wrap of the read index
    write_offs(1, 2);
    write_word(9'h055);
    read_offs(n, m);
    chk(n == 9'h055, "R3 fifth write wraps to slice 0", n, 'h55);
    chk(m == 2, "R3 full offset untouched by wrap", m, 2);
    read_word(w);
    chk(w == 'h55, "R4 fifth read wraps to slice 0", w, 'h55);

    // R8 partial reset keeps offsets, restarts indices
    partial_reset();
    read_offs(n, m);
    chk(n == 'h55 && m == 2, "R8 offsets kept across partial reset", n, 'h55);
    write_offs(7, 9);
    read_offs(n, m);
    chk(n == 7 && m == 9, "R8 write index restarted", n * 100000 + m, 700009);

    // R2 serial input ignored in parallel mode
    for (int i = 0; i < 10; i++) begin
      ser_en = 1; ser_in = 1; @(negedge clk);
    end
    ser_en = 0; ser_in = 0;
    read_offs(n, m);
    chk(n == 7 && m == 9, "R2 serial ignored in parallel mode", n * 100000 + m, 700009);

    // R6 / R7 thresholds
    write_offs(100, 200);
    wr_count = 15'(CAP - 200);
    @(negedge clk);
    chk(almost_full_n == 1'b1, "R6 count equal to limit", almost_full_n, 1);
    wr_count = 15'(CAP - 199);
    #1 chk(almost_full_n == 1'b1, "R6 flag not yet updated", almost_full_n, 1);
    @(negedge clk);
    chk(almost_full_n == 1'b0, "R6 count above limit", almost_full_n, 0);
    wr_count = 15'(CAP);
    @(negedge clk);
    chk(almost_full_n == 1'b0, "R6 count at capacity", almost_full_n, 0);
    wr_count = '0;
    rd_count = 15'd99;
    @(negedge clk);
    chk(almost_empty_n == 1'b0, "R7 count below offset", almost_empty_n, 0);
    rd_count = 15'd100;
    @(negedge clk);
    chk(almost_empty_n == 1'b1, "R7 count equal to offset", almost_empty_n, 1);

    // R1 master reset with ld=1, R2 parallel ignored in serial mode
    master_reset(1'b1);
    read_offs(n, m);
    chk(n == 1023 && m == 1023, "R1 high default loaded", n, 1023);
    chk(almost_empty_n == 1'b0, "R7 count 100 below 1023", almost_empty_n, 0);
    write_offs(5, 6);
    read_offs(n, m);
    chk(n == 1023 && m == 1023, "R2 parallel ignored in serial mode", n, 1023);

    // R5 serial load
    ser_offs('h2A5B, 'h1234);
    read_offs(n, m);
    chk(n == 'h2A5B, "R5 serial empty offset", n, 'h2A5B);
    chk(m == 'h1234, "R5 serial full offset", m, 'h1234);

    // R8 partial reset mid serial stream
    for (int i = 0; i < 3; i++) begin
      ser_en = 1; ser_in = 1; @(negedge clk);
    end
    ser_en = 0; ser_in = 0;
    partial_reset();
    ser_offs(55, 66);
    read_offs(n, m);
    chk(n == 55 && m == 66, "R8 serial position restarted", n * 100000 + m, 5500066);

    // R1 master reset with ld=0 restores low default and parallel mode
    master_reset(1'b0);
    read_offs(n, m);
    chk(n == 127 && m == 127, "R1 low default loaded", n, 127);
    rd_count = 15'd126;
    @(negedge clk);
    chk(almost_empty_n == 1'b0, "R7 count one below 127", almost_empty_n, 0);
    write_offs(11, 12);
    read_offs(n, m);
    chk(n == 11 && m == 12, "R2 parallel method after ld=0", n * 100000 + m, 1100012);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule